// File: doc/BRIEF.md
# Priority Pause Receive Tracker

This block sits behind the receive header parser of an Ethernet MAC. It looks at the fields of each received frame and picks out priority-based pause frames. These are frames sent to the reserved multicast pause address, with EtherType 0x8808 and opcode 0x0101. For each of eight traffic classes it keeps a countdown of pause quanta and reports which classes are currently paused to the transmit client. The block never holds back transmit data itself. The client reads the status vector and throttles its own queues.

A pause frame carries a per-class valid vector and one 16-bit time value per class. A class is reloaded only when three things hold: the frame names it in the valid vector, the local receive-enable mask allows it, and the frame arrived with a good-frame strobe. A reload replaces whatever count was running. A time of zero releases the class at once. Counts then fall by one on every quantum tick. The tick is an input pulse that fires once per 512 bit times: every clock for a 512-bit datapath, every second clock for a 256-bit one. Each class also gives a one-cycle pulse when its pause starts and another when it ends.

Top module: `pfc_rx_tracker`

## Requirements
- R1: A frame reloads class timers only if its destination address equals 48'h0180C2000001, its EtherType equals 16'h8808 and its opcode equals 16'h0101. A frame that misses any one of these leaves every class unchanged.
- R2: Frame fields are taken only in a cycle where `frm_good` is 1. Fields presented while `frm_good` is 0 change no state.
- R3: Class n reloads only while bit n of `rx_class_mask` is 1 in the frame's cycle. A class whose mask bit is 0 keeps its state.
- R4: Class n reloads only when bit n of `frm_class_vec` is 1. Classes whose bit is 0 are unaffected.
- R5: A reload replaces the running count with the received time, whether the new time is larger or smaller. Class n's time is `frm_times[16n+15:16n]`.
- R6: A received time of zero clears the pause of that class immediately.
- R7: A paused class counts down by one on each cycle with `quantum_tick` at 1. Its `class_paused` bit goes low on the edge where the count reaches zero, which is exactly T ticks after a load of T.
- R8: `xoff_start[n]` is 1 for exactly one cycle, the first cycle in which `class_paused[n]` is 1 after being 0. A reload of a class that is already paused gives no pulse.
- R9: `pause_end[n]` is 1 for exactly one cycle, the first cycle in which `class_paused[n]` is 0 after being 1.
- R10: A frame accepted at clock edge k changes `class_paused` at edge k+2. Synchronous reset clears every count, status bit and pulse.
- R11: When a reload and a quantum tick fall in the same cycle, the reload wins and the tick is not applied to the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_good | input | 1 | Strobe: the parsed fields belong to a frame that passed CRC |
| frm_dst | input | 48 | Parsed destination address |
| frm_ethertype | input | 16 | Parsed EtherType |
| frm_opcode | input | 16 | Parsed MAC control opcode |
| frm_class_vec | input | NUM_CLASS | Per-class valid vector from the frame |
| frm_times | input | NUM_CLASS*16 | Per-class pause times; class n at [16n+15:16n] |
| rx_class_mask | input | NUM_CLASS | Local per-class receive enable |
| quantum_tick | input | 1 | One pulse per 512 bit times |
| class_paused | output | NUM_CLASS | Class n currently paused |
| xoff_start | output | NUM_CLASS | One-cycle pulse at pause start |
| pause_end | output | NUM_CLASS | One-cycle pulse at pause end |

## Verification
The bound checker tests four things on every cycle and for every class:
- a pause may only begin two edges after a good frame that arrived while the class mask was set;
- a pause may only end after a tick or a frame;
- the start pulse matches a rising edge of the status bit, in both directions;
- the end pulse implies a falling edge of the status bit.

Some behaviour can only be shown by the bench's directed scenarios, because the checker does not decode frame contents. This covers address, EtherType and opcode rejection, the exact tick count to release, override in both directions, the zero-time release, and load taking priority over a tick.

// File: rtl/pfc_rx_pkg.sv
package pfc_rx_pkg;
  localparam logic [47:0] PFC_DEST_ADDR = 48'h0180C2000001;
  localparam logic [15:0] MAC_CTRL_TYPE = 16'h8808;
  localparam logic [15:0] PFC_OPCODE    = 16'h0101;
  localparam int          TIME_W        = 16;
endpackage

// File: rtl/pfc_frame_decode.sv
module pfc_frame_decode
  import pfc_rx_pkg::*;
#(
  parameter int NUM_CLASS = 8,
  parameter logic [47:0] MATCH_ADDR = PFC_DEST_ADDR
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          frm_good,
  input  logic [47:0]                   frm_dst,
  input  logic [15:0]                   frm_ethertype,
  input  logic [15:0]                   frm_opcode,
  input  logic [NUM_CLASS-1:0]          frm_class_vec,
  input  logic [NUM_CLASS*TIME_W-1:0]   frm_times,
  input  logic [NUM_CLASS-1:0]          rx_class_mask,
  output logic [NUM_CLASS-1:0]          ld_req,
  output logic [NUM_CLASS*TIME_W-1:0]   ld_time
);
  logic addr_hit, type_hit, op_hit, frame_hit;

  always_comb begin
    addr_hit  = (frm_dst == MATCH_ADDR);
    type_hit  = (frm_ethertype == MAC_CTRL_TYPE);
    op_hit    = (frm_opcode == PFC_OPCODE);
    frame_hit = frm_good && addr_hit && type_hit && op_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_req  <= '0;
      ld_time <= '0;
    end else begin
      ld_req <= frame_hit ? (frm_class_vec & rx_class_mask) : '0;
      if (frame_hit) ld_time <= frm_times;
    end
  end
endmodule

// File: rtl/pfc_class_timer.sv
module pfc_class_timer
  import pfc_rx_pkg::*;
#(
  parameter int CNT_W = TIME_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             paused,
  output logic             start_pulse,
  output logic             end_pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             nz_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (load)
      cnt_nxt = load_val;
    else if (tick && (cnt_q != '0))
      cnt_nxt = cnt_q - 1'b1;
    nz_nxt = (cnt_nxt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      paused      <= 1'b0;
      start_pulse <= 1'b0;
      end_pulse   <= 1'b0;
    end else begin
      cnt_q       <= cnt_nxt;
      paused      <= nz_nxt;
      start_pulse <= nz_nxt && !paused;
      end_pulse   <= !nz_nxt && paused;
    end
  end
endmodule

// File: rtl/pfc_rx_tracker.sv
module pfc_rx_tracker
  import pfc_rx_pkg::*;
#(
  parameter int NUM_CLASS = 8,
  parameter logic [47:0] MATCH_ADDR = PFC_DEST_ADDR
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frm_good,
  input  logic [47:0]                 frm_dst,
  input  logic [15:0]                 frm_ethertype,
  input  logic [15:0]                 frm_opcode,
  input  logic [NUM_CLASS-1:0]        frm_class_vec,
  input  logic [NUM_CLASS*TIME_W-1:0] frm_times,
  input  logic [NUM_CLASS-1:0]        rx_class_mask,
  input  logic                        quantum_tick,
  output logic [NUM_CLASS-1:0]        class_paused,
  output logic [NUM_CLASS-1:0]        xoff_start,
  output logic [NUM_CLASS-1:0]        pause_end
);
  logic [NUM_CLASS-1:0]        ld_req;
  logic [NUM_CLASS*TIME_W-1:0] ld_time;

  pfc_frame_decode #(
    .NUM_CLASS (NUM_CLASS),
    .MATCH_ADDR(MATCH_ADDR)
  ) u_decode (
    .clk          (clk),
    .rst          (rst),
    .frm_good     (frm_good),
    .frm_dst      (frm_dst),
    .frm_ethertype(frm_ethertype),
    .frm_opcode   (frm_opcode),
    .frm_class_vec(frm_class_vec),
    .frm_times    (frm_times),
    .rx_class_mask(rx_class_mask),
    .ld_req       (ld_req),
    .ld_time      (ld_time)
  );

  for (genvar n = 0; n < NUM_CLASS; n++) begin : g_class
    pfc_class_timer #(
      .CNT_W(TIME_W)
    ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .load       (ld_req[n]),
      .load_val   (ld_time[n*TIME_W +: TIME_W]),
      .tick       (quantum_tick),
      .paused     (class_paused[n]),
      .start_pulse(xoff_start[n]),
      .end_pulse  (pause_end[n])
    );
  end
endmodule

// File: rtl/pfc_rx_tracker_sva.sv
module pfc_rx_tracker_sva #(
  parameter int NUM_CLASS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 frm_good,
  input logic [NUM_CLASS-1:0] rx_class_mask,
  input logic                 quantum_tick,
  input logic [NUM_CLASS-1:0] class_paused,
  input logic [NUM_CLASS-1:0] xoff_start,
  input logic [NUM_CLASS-1:0] pause_end
);
  for (genvar n = 0; n < NUM_CLASS; n++) begin : g_chk
    // R2: a pause can only begin two edges after a good frame
    a_r2_needs_good: assert property (@(posedge clk) disable iff (rst)
      (class_paused[n] && !$past(class_paused[n])) |-> $past(frm_good, 2));
    // R3: a pause can only begin if the class mask was set with the frame
    a_r3_mask_gate: assert property (@(posedge clk) disable iff (rst)
      (class_paused[n] && !$past(class_paused[n])) |-> $past(rx_class_mask[n], 2));
    // R7: release only follows a tick or a frame
    a_r7_release_cause: assert property (@(posedge clk) disable iff (rst)
      (!class_paused[n] && $past(class_paused[n])) |->
        ($past(quantum_tick) || $past(frm_good, 2)));
    // R8: start pulse implies a rising status bit
    a_r8_start_edge: assert property (@(posedge clk) disable iff (rst)
      xoff_start[n] |-> (class_paused[n] && !$past(class_paused[n])));
    // R8: a rising status bit implies a start pulse
    a_r8_start_seen: assert property (@(posedge clk) disable iff (rst)
      (class_paused[n] && !$past(class_paused[n])) |-> xoff_start[n]);
    // R9: end pulse implies a falling status bit
    a_r9_end_edge: assert property (@(posedge clk) disable iff (rst)
      pause_end[n] |-> (!class_paused[n] && $past(class_paused[n])));
  end
endmodule

bind pfc_rx_tracker pfc_rx_tracker_sva #(.NUM_CLASS(NUM_CLASS)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .frm_good     (frm_good),
  .rx_class_mask(rx_class_mask),
  .quantum_tick (quantum_tick),
  .class_paused (class_paused),
  .xoff_start   (xoff_start),
  .pause_end    (pause_end)
);

// File: tb/pfc_rx_tracker_tb.sv
module pfc_rx_tracker_tb;
  localparam int NC = 8;
  localparam int TW = 16;
  localparam logic [47:0] GOOD_DA = 48'h0180C2000001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_good = 1'b0;
  logic [47:0] frm_dst = '0;
  logic [15:0] frm_ethertype = '0;
  logic [15:0] frm_opcode = '0;
  logic [NC-1:0] frm_class_vec = '0;
  logic [NC*TW-1:0] frm_times = '0;
  logic [NC-1:0] rx_class_mask = '1;
  logic quantum_tick = 1'b0;
  logic [NC-1:0] class_paused, xoff_start, pause_end;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfc_rx_tracker #(.NUM_CLASS(NC)) u_dut (
    .clk(clk), .rst(rst), .frm_good(frm_good), .frm_dst(frm_dst),
    .frm_ethertype(frm_ethertype), .frm_opcode(frm_opcode),
    .frm_class_vec(frm_class_vec), .frm_times(frm_times),
    .rx_class_mask(rx_class_mask), .quantum_tick(quantum_tick),
    .class_paused(class_paused), .xoff_start(xoff_start), .pause_end(pause_end)
  );

  task automatic check(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [NC*TW-1:0] fill_times(input logic [TW-1:0] v);
    logic [NC*TW-1:0] r;
    for (int i = 0; i < NC; i++) r[i*TW +: TW] = v;
    return r;
  endfunction

  // Drives one frame cycle; returns at the negedge after the sampling edge.
  task automatic send(input logic [47:0] da, input logic [15:0] et, input logic [15:0] op,
                      input logic [NC-1:0] cv, input logic [NC*TW-1:0] tm, input logic good);
    @(negedge clk);
    frm_dst = da; frm_ethertype = et; frm_opcode = op;
    frm_class_vec = cv; frm_times = tm; frm_good = good;
    @(negedge clk);
    frm_good = 1'b0;
  endtask

  task automatic send_pfc(input logic [NC-1:0] cv, input logic [NC*TW-1:0] tm);
    send(GOOD_DA, 16'h8808, 16'h0101, cv, tm, 1'b1);
  endtask

  task automatic clear_all();
    quantum_tick = 1'b0;
    rx_class_mask = '1;
    send_pfc('1, '0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 reset paused", class_paused, '0);
    check("R10 reset start", xoff_start, '0);
    check("R10 reset end", pause_end, '0);
  endtask

  task automatic t_latency();
    clear_all();
    send_pfc(8'h01, fill_times(16'd10));
    check("R10 no change at k+1", class_paused, '0);
    @(negedge clk);
    check("R10 paused at k+2", class_paused, 8'h01);
    check("R8 start pulse", xoff_start, 8'h01);
    @(negedge clk);
    check("R8 start pulse one cycle", xoff_start, '0);
  endtask

  task automatic t_match();
    clear_all();
    send(48'h0180C2000002, 16'h8808, 16'h0101, '1, fill_times(16'd5), 1'b1);
    send(GOOD_DA, 16'h8809, 16'h0101, '1, fill_times(16'd5), 1'b1);
    send(GOOD_DA, 16'h8808, 16'h0001, '1, fill_times(16'd5), 1'b1);
    repeat (2) @(negedge clk);
    check("R1 mismatched frames ignored", class_paused, '0);
    send(GOOD_DA, 16'h8808, 16'h0101, '1, fill_times(16'd5), 1'b0);
    repeat (2) @(negedge clk);
    check("R2 no good strobe ignored", class_paused, '0);
  endtask

  task automatic t_masks();
    clear_all();
    rx_class_mask = 8'hF7;
    send_pfc('1, fill_times(16'd7));
    rx_class_mask = '1;
    @(negedge clk);
    check("R3 masked class 3 untouched", class_paused, 8'hF7);
    clear_all();
    send_pfc(8'h20, fill_times(16'd7));
    @(negedge clk);
    check("R4 only class 5 enabled", class_paused, 8'h20);
  endtask

  task automatic t_countdown();
    clear_all();
    send_pfc(8'h02, fill_times(16'd3));
    @(negedge clk);
    check("R7 loaded", class_paused, 8'h02);
    quantum_tick = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 still paused after 2 ticks", class_paused, 8'h02);
    @(negedge clk);
    quantum_tick = 1'b0;
    check("R7 released after 3 ticks", class_paused, '0);
    check("R9 end pulse", pause_end, 8'h02);
    @(negedge clk);
    check("R9 end pulse one cycle", pause_end, '0);
    // half-rate tick: load 2, ticks on alternate clocks
    send_pfc(8'h04, fill_times(16'd2));
    @(negedge clk);
    quantum_tick = 1'b1; @(negedge clk);
    quantum_tick = 1'b0; @(negedge clk);
    check("R7 half-rate one tick left", class_paused, 8'h04);
    quantum_tick = 1'b1; @(negedge clk);
    quantum_tick = 1'b0;
    check("R7 half-rate released", class_paused, '0);
  endtask

  task automatic t_override();
    logic [NC*TW-1:0] tm;
    clear_all();
    send_pfc(8'h01, fill_times(16'd50));
    @(negedge clk);
    send_pfc(8'h01, fill_times(16'd2));
    @(negedge clk);
    check("R8 no start on reload", xoff_start, '0);
    quantum_tick = 1'b1; repeat (2) @(negedge clk); quantum_tick = 1'b0;
    check("R5 smaller value wins", class_paused, '0);
    send_pfc(8'h01, fill_times(16'd1));
    @(negedge clk);
    send_pfc(8'h01, fill_times(16'd4));
    @(negedge clk);
    quantum_tick = 1'b1; @(negedge clk); quantum_tick = 1'b0;
    check("R5 larger value wins", class_paused, 8'h01);
    tm = fill_times(16'd9);
    tm[0 +: TW] = 16'd0;
    send_pfc(8'h03, tm);
    @(negedge clk);
    check("R6 zero time releases", class_paused, 8'h02);
    check("R9 end pulse on zero time", pause_end, 8'h01);
  endtask

  task automatic t_load_vs_tick();
    clear_all();
    send_pfc(8'h10, fill_times(16'd9));
    @(negedge clk);
    quantum_tick = 1'b1;
    send_pfc(8'h10, fill_times(16'd2));
    @(negedge clk);
    check("R11 loaded despite tick", class_paused, 8'h10);
    @(negedge clk);
    check("R11 one tick left", class_paused, 8'h10);
    @(negedge clk);
    quantum_tick = 1'b0;
    check("R11 released after two ticks", class_paused, '0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_match();
    t_masks();
    t_countdown();
    t_override();
    t_load_vs_tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule